// File: doc/BRIEF.md
# CAN Receive Ping-Pong Buffer Controller

This block holds received CAN messages in two 13-byte slots that act as a two-deep receive queue. An upstream frame receiver streams each frame's bytes (control bits, identifier, data) into the hidden "back" slot. The CPU reads the "front" slot through a small address/data read port. When the end-of-frame strobe arrives, the block decides from the filter verdict, the frame's origin and its own flags whether the back slot becomes the new front slot.

Promotion does not copy bytes. The two slots are the two halves of one dual-port memory, and promotion only toggles a one-bit bank pointer. The block keeps a receive-full flag, which software clears to release the front slot. It also keeps a write-one-to-clear overrun flag. It raises a maskable receive interrupt and a maskable error interrupt. Frames that this node transmitted and kept the bus for are left in the back slot, unless loop-back mode is on.

Top module: `canrx_pingpong`

## Requirements
- R1: Bytes presented on the write port at index 0..12 are stored into the back slot whether or not the frame is later accepted. The front slot byte at `rd_idx` appears on `rd_data` one clock after the address is applied.
- R2: A frame counts as accepted when `frame_ok` and `filt_hit` are both high. If `rx_full` is clear, an accepted frame is promoted to the front slot and `rx_full` is set on the next clock. A frame with `filt_hit` low changes no flag.
- R3: If `rx_full` is set and the back slot is free, an accepted frame is parked in the back slot. When software later pulses `clr_full`, the parked frame is promoted in that same clock and `rx_full` stays set.
- R4: An accepted frame that completes while a frame is parked is discarded and sets `ovr_flag`. While a frame is parked, writes into the back slot are blocked, so the parked frame survives.
- R5: A frame with `own_tx` high and `loopback` low changes neither the front slot nor any flag.
- R6: With `loopback` high, a frame with `own_tx` high is handled exactly like any other frame.
- R7: When `clr_full` and an accepted `frame_ok` fall in the same clock, the clear is applied first. With no parked frame, the new frame is promoted and `rx_full` stays set. With a parked frame, the parked frame is promoted and the new frame is discarded as an overrun.
- R8: `rx_irq` equals `rx_full AND rx_ie`, and `err_irq` equals `ovr_flag AND ovr_ie`. Both are registered, so a change of an enable shows after one clock.
- R9: A pulse on `clr_ovr` clears `ovr_flag` unless an overrun occurs in the same clock. `clr_full` releases the front slot and clears `rx_full` when no frame is parked.
- R10: A synchronous reset clears `rx_full`, `ovr_flag`, both interrupts and the parked state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe from the frame receiver |
| wr_idx | input | 4 | Byte index within the back slot (0..12) |
| wr_data | input | 8 | Byte to store |
| frame_ok | input | 1 | End of a correctly received frame |
| filt_hit | input | 1 | Identifier filter accepted the frame (valid with frame_ok) |
| own_tx | input | 1 | Frame was sent by this node and arbitration was kept |
| loopback | input | 1 | Loop-back mode: own frames are treated as foreign |
| clr_full | input | 1 | Software release of the front slot |
| clr_ovr | input | 1 | Write-one-to-clear of the overrun flag |
| rx_ie | input | 1 | Receive interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rd_idx | input | 4 | Front slot byte index to read |
| rd_data | output | 8 | Front slot byte, one clock after rd_idx |
| rx_full | output | 1 | Front slot holds an unread frame |
| ovr_flag | output | 1 | An accepted frame was discarded |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Overrun interrupt |

## Verification
The interesting collision is software releasing the front slot in the same clock that the frame receiver finishes an accepted frame. The bench provokes this twice by raising `clr_full` together with `frame_ok`: once with the back slot free and once with a frame parked in it. It then judges the outcome from the flags and from bytes 0 and 12 read back from the front slot. In the first case the new frame must be visible. In the second case the parked frame must be visible and `ovr_flag` must be set.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  // Outcome of an end-of-frame strobe
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_PROMOTE = 2'd1,
    EV_PARK    = 2'd2,
    EV_DROP    = 2'd3
  } rx_evt_e;
endpackage

// File: rtl/canrx_bank_ram.sv
module canrx_bank_ram #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/canrx_flag_ctrl.sv
module canrx_flag_ctrl
  import canrx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_ok,
  input  logic filt_hit,
  input  logic own_tx,
  input  logic loopback,
  input  logic clr_full,
  input  logic clr_ovr,
  input  logic rx_ie,
  input  logic ovr_ie,
  output logic fg_sel,
  output logic bg_held,
  output logic rx_full,
  output logic ovr_flag,
  output logic rx_irq,
  output logic err_irq
);
  logic    fg_q, held_q, full_q, ovr_q;
  logic    fg_n, held_n, full_n, ovr_n;
  logic    accept;
  rx_evt_e evt;

  assign accept = frame_ok & filt_hit & (~own_tx | loopback);

  always_comb begin
    evt = EV_NONE;
    if (accept) begin
      if (held_q)                   evt = EV_DROP;
      else if (full_q && !clr_full) evt = EV_PARK;
      else                          evt = EV_PROMOTE;
    end
  end

  always_comb begin
    fg_n   = fg_q;
    held_n = held_q;
    full_n = full_q;
    ovr_n  = ovr_q & ~clr_ovr;
    if (clr_full && full_q) begin
      if (held_q) begin
        fg_n   = ~fg_q;
        held_n = 1'b0;
      end else begin
        full_n = 1'b0;
      end
    end
    case (evt)
      EV_PROMOTE: begin
        fg_n   = ~fg_q;
        full_n = 1'b1;
      end
      EV_PARK: held_n = 1'b1;
      EV_DROP: ovr_n  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_q    <= 1'b0;
      held_q  <= 1'b0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      fg_q    <= fg_n;
      held_q  <= held_n;
      full_q  <= full_n;
      ovr_q   <= ovr_n;
      rx_irq  <= full_n & rx_ie;
      err_irq <= ovr_n & ovr_ie;
    end
  end

  assign fg_sel   = fg_q;
  assign bg_held  = held_q;
  assign rx_full  = full_q;
  assign ovr_flag = ovr_q;

  // R2
  full_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> $past(frame_ok && filt_hit));

  // R3
  park_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    held_q |-> full_q);

  // R4
  ovr_needs_park_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(held_q));

  // R5
  own_frame_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && own_tx && !loopback && !clr_full)
      |=> (full_q == $past(full_q)) && (fg_q == $past(fg_q)) && (held_q == $past(held_q)));

  // R8
  rx_irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!full_q && !ovr_q && !held_q));
endmodule

// File: rtl/canrx_pingpong.sv
module canrx_pingpong #(
  parameter int DATA_W    = 8,
  parameter int MSG_BYTES = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_ok,
  input  logic              filt_hit,
  input  logic              own_tx,
  input  logic              loopback,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              rx_ie,
  input  logic              ovr_ie,
  input  logic [3:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_full,
  output logic              ovr_flag,
  output logic              rx_irq,
  output logic              err_irq
);
  localparam int IDX_W = $clog2(MSG_BYTES);
  localparam int RAM_AW = IDX_W + 1;

  logic              fg_sel, bg_held, in_range, ram_we;
  logic [RAM_AW-1:0] waddr, raddr;

  assign in_range = ({28'd0, wr_idx} < MSG_BYTES);
  assign ram_we   = wr_en & ~bg_held & in_range;
  assign waddr    = {~fg_sel, wr_idx[IDX_W-1:0]};
  assign raddr    = { fg_sel, rd_idx[IDX_W-1:0]};

  canrx_flag_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .frame_ok (frame_ok),
    .filt_hit (filt_hit),
    .own_tx   (own_tx),
    .loopback (loopback),
    .clr_full (clr_full),
    .clr_ovr  (clr_ovr),
    .rx_ie    (rx_ie),
    .ovr_ie   (ovr_ie),
    .fg_sel   (fg_sel),
    .bg_held  (bg_held),
    .rx_full  (rx_full),
    .ovr_flag (ovr_flag),
    .rx_irq   (rx_irq),
    .err_irq  (err_irq)
  );

  canrx_bank_ram #(.DW(DATA_W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );

  // R4
  no_write_parked_chk: assert property (@(posedge clk) disable iff (rst)
    bg_held |-> !ram_we);
endmodule

// File: tb/canrx_pingpong_tb.sv
module canrx_pingpong_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, frame_ok = 0, filt_hit = 0, own_tx = 0, loopback = 0;
  logic       clr_full = 0, clr_ovr = 0, rx_ie = 1, ovr_ie = 1;
  logic [3:0] wr_idx = 0, rd_idx = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       rx_full, ovr_flag, rx_irq, err_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  canrx_pingpong u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .frame_ok(frame_ok), .filt_hit(filt_hit), .own_tx(own_tx), .loopback(loopback),
    .clr_full(clr_full), .clr_ovr(clr_ovr), .rx_ie(rx_ie), .ovr_ie(ovr_ie),
    .rd_idx(rd_idx), .rd_data(rd_data), .rx_full(rx_full), .ovr_flag(ovr_flag),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );

  // op: 0 frame with bytes, 1 clr_full pulse, 2 clr_ovr pulse, 3 end strobe without bytes
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] tag;
    logic       filt, own, lb, clr;
    logic       efull, eovr;
    logic [7:0] efg;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10},
    '{2'd0, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10},
    '{2'd0, 8'h30, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10},
    '{2'd0, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10},
    '{2'd0, 8'h50, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h10},
    '{2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h40},
    '{2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h40},
    '{2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40},
    '{2'd0, 8'h60, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h60},
    '{2'd0, 8'h70, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h70},
    '{2'd0, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h70},
    '{2'd0, 8'h90, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h80},
    '{2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80},
    '{2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80},
    '{2'd0, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80},
    '{2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5}
  };
  string vreq [NV] = '{"R2", "R2", "R5", "R3", "R4", "R3", "R9", "R9",
                       "R6", "R7", "R3", "R7", "R9", "R9", "R1", "R1"};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input bit with_bytes, input logic [7:0] tag,
                      input bit filt, input bit own, input bit lb, input bit clr);
    if (with_bytes) begin
      for (int i = 0; i < 13; i++) begin
        @(negedge clk);
        wr_en = 1; wr_idx = 4'(i); wr_data = tag + 8'(i);
      end
    end
    @(negedge clk);
    wr_en = 0; frame_ok = 1; filt_hit = filt; own_tx = own; loopback = lb; clr_full = clr;
    @(negedge clk);
    frame_ok = 0; filt_hit = 0; own_tx = 0; loopback = 0; clr_full = 0;
  endtask

  task automatic pulse(input bit full_c, input bit ovr_c);
    @(negedge clk);
    clr_full = full_c; clr_ovr = ovr_c;
    @(negedge clk);
    clr_full = 0; clr_ovr = 0;
  endtask

  task automatic check_fg(input string req, input logic [7:0] tag);
    rd_idx = 4'd0;
    @(negedge clk);
    chk(rd_data == tag, req, "front byte 0", rd_data, tag);
    rd_idx = 4'd12;
    @(negedge clk);
    chk(rd_data == tag + 8'd12, req, "front byte 12", rd_data, tag + 8'd12);
  endtask

  task automatic check_flags(input string req, input bit ef, input bit eo);
    chk(rx_full == ef, req, "rx_full", 8'(rx_full), 8'(ef));
    chk(ovr_flag == eo, req, "ovr_flag", 8'(ovr_flag), 8'(eo));
    chk(rx_irq == (ef & rx_ie), "R8", "rx_irq", 8'(rx_irq), 8'(ef & rx_ie));
    chk(err_irq == (eo & ovr_ie), "R8", "err_irq", 8'(err_irq), 8'(eo & ovr_ie));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check_flags("R10", 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v].op)
        2'd0: send(1'b1, VEC[v].tag, VEC[v].filt, VEC[v].own, VEC[v].lb, VEC[v].clr);
        2'd1: pulse(1'b1, 1'b0);
        2'd2: pulse(1'b0, 1'b1);
        default: send(1'b0, 8'h00, VEC[v].filt, 1'b0, 1'b0, 1'b0);
      endcase
      check_flags(vreq[v], VEC[v].efull, VEC[v].eovr);
      check_fg(vreq[v], VEC[v].efg);
    end

    // R8: masked receive interrupt, then enabled
    pulse(1'b1, 1'b0);
    rx_ie = 0;
    send(1'b1, 8'hB0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_flags("R8", 1'b1, 1'b0);
    rx_ie = 1;
    @(negedge clk);
    chk(rx_irq == 1'b1, "R8", "rx_irq after enable", 8'(rx_irq), 8'd1);

    // R8: masked overrun interrupt, then enabled
    ovr_ie = 0;
    send(1'b1, 8'hC0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(1'b1, 8'hD0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_flags("R8", 1'b1, 1'b1);
    ovr_ie = 1;
    @(negedge clk);
    chk(err_irq == 1'b1, "R8", "err_irq after enable", 8'(err_irq), 8'd1);

    // R10: reset clears flags and the parked frame
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check_flags("R10", 1'b0, 1'b0);
    send(1'b1, 8'hE0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_flags("R10", 1'b1, 1'b0);
    check_fg("R10", 8'hE0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule